// File: doc/BRIEF.md
# Nine-Bit Address-Wake Serial Receiver

This block receives asynchronous serial frames and is meant for a shared line where one sender talks to several listeners. A frame is a low start bit, eight data bits sent least significant first, an optional ninth bit, and a stop bit. The line is sampled on every pulse of a tick enable that runs at sixteen times the bit rate. Each received bit is taken as the majority of three samples around the middle of its bit period. When a frame completes, the eight data bits go to a receive buffer, a separate flag holds one extra bit, and a completion flag is raised for the host.

In nine-bit mode the extra bit is the ninth frame bit. A ninth bit of 1 marks an address frame and 0 marks a data frame. While the address-wake enable is set, data frames are dropped without raising the completion flag, so an idle listener only sees address frames. A listener that recognises its own address clears the enable, takes the data frames that follow, and then sets the enable again. In ten-bit mode there is no ninth bit, and the extra flag holds the sampled stop bit. In that mode the enable only accepts frames whose stop bit is valid.

The host clears the completion flag through a one-cycle clear strobe. A frame that completes while the flag is still set is discarded.

Top module: `addr_wake_rx`

## Requirements
- R1: After reset `rxDone` is 0, `rxData` is 0x00 and `rxBit8` is 0.
- R2: A frame is low start bit, eight data bits LSB first, then in nine-bit mode (`nineBitMode`=1) a ninth bit and a high stop bit. On acceptance `rxData` holds the eight data bits, `rxBit8` the ninth bit, and `rxDone` rises at the middle of the stop bit. `rxData` changes only in the cycle where `rxDone` rises.
- R3: In nine-bit mode with `mpEnable`=1, a frame whose ninth bit is 0 leaves `rxDone`, `rxData` and `rxBit8` unchanged.
- R4: In nine-bit mode with `mpEnable`=1, a frame whose ninth bit is 1 is accepted and sets `rxDone`.
- R5: In nine-bit mode with `mpEnable`=0, every frame is accepted, whatever its ninth bit.
- R6: In ten-bit mode (`nineBitMode`=0) the frame has eight data bits and `rxBit8` receives the sampled stop bit. With `mpEnable`=1 the frame is accepted only when that stop bit is 1. A frame with a low stop bit leaves all outputs unchanged.
- R7: In ten-bit mode with `mpEnable`=0, a frame is accepted even when its stop bit is sampled low, and `rxBit8` is then 0.
- R8: A low pulse on `rxLine` that is no longer high-low when samples 7, 8 and 9 (counted from the falling edge, in ticks) are voted is a false start. It changes no output, and the next frame is received normally.
- R9: A data bit is the majority of samples 7, 8 and 9 of its period. A disturbance that flips only sample 8 does not change the received value.
- R10: While `rxDone` is 1, a completed frame is discarded and the outputs hold. A one-cycle `clrDone` pulse clears `rxDone` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxLine | input | 1 | Serial input, high when idle |
| nineBitMode | input | 1 | 1: nine-bit frame, 0: ten-bit frame (eight data bits) |
| mpEnable | input | 1 | Address-wake / stop-check enable |
| clrDone | input | 1 | Host strobe that clears the completion flag |
| rxData | output | 8 | Receive buffer |
| rxBit8 | output | 1 | Ninth bit (nine-bit mode) or stop bit (ten-bit mode) |
| rxDone | output | 1 | Completion flag |

## Verification
The assertions assume that `nineBitMode` and `mpEnable` only change between frames. They also assume that `clrDone` is never pulsed in the same cycle in which a frame completes, and that `tickEn` is a single-cycle pulse. The stimulus follows all of these rules. It changes mode and enable only while the line is idle after a frame's completion point, and it issues host clears only after the whole frame and its idle gap have been sent. Every bit is held for exactly sixteen ticks, with the tick every fourth clock. The only departures from clean bit periods are the deliberate short start pulse and single-sample glitches, which are placed so they meet one vote sample.

// File: rtl/awrx_pkg.sv
package awrx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxPhase_t;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic takeSample;  // push current line sample into vote history
    logic shiftBit;    // push the voted bit into the frame shifter
    logic commit;      // frame accepted by the control
    logic commitBit8;  // value for the extra-bit flag on commit
  } rxStrobe_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/awrx_datapath.sv
module awrx_datapath
  import awrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rxLine,
  input  logic              nineBitMode,
  input  logic              clrDone,
  input  rxStrobe_t         strobe,
  output logic              fallSeen,
  output logic              voteBit,
  output logic              ninthBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxDone
);

  localparam int SHIFT_W = DATA_W + 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineS;
  logic                   prevLine;
  logic [1:0]             voteHist;
  logic [SHIFT_W-1:0]     shiftReg;
  logic [DATA_W-1:0]      frameData;
  logic                   loadNow;

  // input synchronizer, depth set by parameter
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[0] <= 1'b1;
        else       syncChain[0] <= rxLine;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b1;
        else       syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign lineS = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevLine <= 1'b1;
    else if (tickEn) prevLine <= lineS;
  end

  assign fallSeen = prevLine & ~lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  voteHist <= 2'b11;
    else if (strobe.takeSample) voteHist <= {voteHist[0], lineS};
  end

  assign voteBit = vote3(voteHist[1], voteHist[0], lineS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {voteBit, shiftReg[SHIFT_W-1:1]};
  end

  assign ninthBit  = shiftReg[SHIFT_W-1];
  assign frameData = nineBitMode ? shiftReg[DATA_W-1:0] : shiftReg[SHIFT_W-1:1];
  assign loadNow   = strobe.commit & ~rxDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit8 <= 1'b0;
      rxDone <= 1'b0;
    end else if (loadNow) begin
      rxData <= frameData;
      rxBit8 <= strobe.commitBit8;
      rxDone <= 1'b1;
    end else if (clrDone) begin
      rxDone <= 1'b0;
    end
  end

endmodule

// File: rtl/awrx_control.sv
module awrx_control
  import awrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int MID        = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      nineBitMode,
  input  logic      mpEnable,
  input  logic      fallSeen,
  input  logic      voteBit,
  input  logic      ninthBit,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] SMP_LO  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] SMP_MID = CNT_W'(MID);
  localparam logic [CNT_W-1:0] SMP_HI  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST9   = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST8   = BIT_W'(DATA_W - 1);

  rxPhase_t         phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             active;
  logic             atDecide;
  logic             accept;

  assign active   = (phase != RX_IDLE);
  assign cntNext  = (cnt == CNT_TOP) ? '0 : cnt + 1'b1;
  assign atDecide = tickEn & active & (cntNext == SMP_HI);
  assign lastBit  = nineBitMode ? LAST9 : LAST8;
  assign accept   = nineBitMode ? (~mpEnable | ninthBit) : (~mpEnable | voteBit);

  always_comb begin
    strobe            = '0;
    strobe.takeSample = tickEn & active & ((cntNext == SMP_LO) | (cntNext == SMP_MID));
    strobe.shiftBit   = atDecide & (phase == RX_DATA);
    strobe.commit     = atDecide & (phase == RX_STOP) & accept;
    strobe.commitBit8 = nineBitMode ? ninthBit : voteBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= RX_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
    end else if (tickEn) begin
      if (phase == RX_IDLE) begin
        if (fallSeen) begin
          phase <= RX_START;
          cnt   <= '0;
        end
      end else begin
        cnt <= cntNext;
        if (atDecide) begin
          unique case (phase)
            RX_START: begin
              bitCnt <= '0;
              phase  <= voteBit ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == lastBit) phase <= RX_STOP;
            end
            RX_STOP: phase <= RX_IDLE;
            default: phase <= RX_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/addr_wake_rx.sv
module addr_wake_rx
  import awrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int MID         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rxLine,
  input  logic              nineBitMode,
  input  logic              mpEnable,
  input  logic              clrDone,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxDone
);

  rxStrobe_t strobe;
  logic      fallSeen;
  logic      voteBit;
  logic      ninthBit;

  awrx_control #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE),
    .MID       (MID)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .nineBitMode(nineBitMode),
    .mpEnable   (mpEnable),
    .fallSeen   (fallSeen),
    .voteBit    (voteBit),
    .ninthBit   (ninthBit),
    .strobe     (strobe)
  );

  awrx_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .rxLine     (rxLine),
    .nineBitMode(nineBitMode),
    .clrDone    (clrDone),
    .strobe     (strobe),
    .fallSeen   (fallSeen),
    .voteBit    (voteBit),
    .ninthBit   (ninthBit),
    .rxData     (rxData),
    .rxBit8     (rxBit8),
    .rxDone     (rxDone)
  );

endmodule

// File: rtl/awrx_checker.sv
module awrx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              nineBitMode,
  input logic              mpEnable,
  input logic              clrDone,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit8,
  input logic              rxDone
);

  // R2
  buffer_only_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(rxDone) |-> $stable(rxData));

  // R3
  wake_needs_address_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) && nineBitMode && $past(mpEnable) |-> rxBit8);

  // R6
  stop_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) && !nineBitMode && $past(mpEnable) |-> rxBit8);

  // R10
  hold_while_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !clrDone |=> rxDone && $stable(rxData) && $stable(rxBit8));

  // R10
  host_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && clrDone |=> !rxDone);

endmodule

bind addr_wake_rx awrx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .nineBitMode(nineBitMode),
  .mpEnable   (mpEnable),
  .clrDone    (clrDone),
  .rxData     (rxData),
  .rxBit8     (rxBit8),
  .rxDone     (rxDone)
);

// File: tb/sim_addr_wake_rx.sv
module sim_addr_wake_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       rxLine = 1'b1;
  logic       nineBitMode = 1'b1;
  logic       mpEnable = 1'b0;
  logic       clrDone = 1'b0;
  logic [7:0] rxData;
  logic       rxBit8;
  logic       rxDone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference state
  logic [7:0] expData = 8'h00;
  logic       expBit8 = 1'b0;
  logic       expDone = 1'b0;
  int         pendT = -1;
  int         clrT = -1;
  logic [7:0] pendData;
  logic       pendNine, pendB9, pendStop;

  addr_wake_rx u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxLine(rxLine),
    .nineBitMode(nineBitMode), .mpEnable(mpEnable), .clrDone(clrDone),
    .rxData(rxData), .rxBit8(rxBit8), .rxDone(rxDone)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic applyModel();
    if (pendT == cyc) begin
      pendT = -1;
      if (!expDone) begin
        if (pendNine ? (!mpEnable || pendB9) : (!mpEnable || pendStop)) begin
          expData = pendData;
          expBit8 = pendNine ? pendB9 : pendStop;
          expDone = 1'b1;
        end
      end
    end
    if (clrT == cyc) begin
      clrT = -1;
      expDone = 1'b0;
    end
  endtask

  task automatic compareAll();
    checks++;
    if (rxData !== expData || rxBit8 !== expBit8 || rxDone !== expDone) begin
      errors++;
      $display("FAIL %s cycle %0d: actual data=%h bit8=%b done=%b expected data=%h bit8=%b done=%b",
               curReq, cyc, rxData, rxBit8, rxDone, expData, expBit8, expDone);
    end
  endtask

  task automatic step(input logic lv, input logic clr);
    @(negedge clk);
    applyModel();
    compareAll();
    rxLine  = lv;
    clrDone = clr;
    tickEn  = ((cyc + 1) % 4 == 0);
    if (clr) clrT = cyc + 1;
  endtask

  task automatic expectVals(input string req, input logic [7:0] d, input logic b8, input logic dn);
    checks++;
    if (rxData !== d || rxBit8 !== b8 || rxDone !== dn) begin
      errors++;
      $display("FAIL %s: actual data=%h bit8=%b done=%b expected data=%h bit8=%b done=%b",
               req, rxData, rxBit8, rxDone, d, b8, dn);
    end
  endtask

  // plays one frame; glitchBit >= 0 flips only the middle vote sample of that bit
  task automatic playFrame(input logic [7:0] d, input logic b9, input logic stopv,
                           input int glitchBit, input int glitchBit2);
    logic [10:0] bits;
    int nb;
    int p0;
    nb = nineBitMode ? 11 : 10;
    bits = '1;
    bits[0] = 1'b0;
    bits[8:1] = d;
    if (nineBitMode) begin
      bits[9] = b9;
      bits[10] = stopv;
    end else begin
      bits[9] = stopv;
    end
    while ((cyc + 2) % 4 != 0) step(1'b1, 1'b0);
    p0 = cyc + 2;
    pendData = d;
    pendNine = nineBitMode;
    pendB9 = b9;
    pendStop = stopv;
    pendT = p0 + (nineBitMode ? 680 : 616);
    for (int k = 0; k < nb * 64 + 32; k++) begin
      logic v;
      int b;
      int off;
      b = k / 64;
      off = k % 64;
      v = (k < nb * 64) ? bits[b] : 1'b1;
      if ((b == glitchBit || b == glitchBit2) && off >= 33 && off <= 35) v = ~v;
      step(v, 1'b0);
    end
  endtask

  task automatic hostClear();
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    rstN = 1'b1;
    step(1'b1, 1'b0);
    expectVals("R1", 8'h00, 1'b0, 1'b0);

    // R2 / R5: nine-bit, enable off, data frame and address frame
    curReq = "R5";
    nineBitMode = 1'b1; mpEnable = 1'b0;
    playFrame(8'hA5, 1'b0, 1'b1, -1, -1);
    expectVals("R5", 8'hA5, 1'b0, 1'b1);
    hostClear();
    expectVals("R10", 8'hA5, 1'b0, 1'b0);
    curReq = "R2";
    playFrame(8'h3C, 1'b1, 1'b1, -1, -1);
    expectVals("R2", 8'h3C, 1'b1, 1'b1);
    hostClear();

    // R3: data frame suppressed with enable on
    curReq = "R3";
    mpEnable = 1'b1;
    playFrame(8'h77, 1'b0, 1'b1, -1, -1);
    expectVals("R3", 8'h3C, 1'b1, 1'b0);

    // R4: address frame wakes
    curReq = "R4";
    playFrame(8'h12, 1'b1, 1'b1, -1, -1);
    expectVals("R4", 8'h12, 1'b1, 1'b1);
    hostClear();

    // addressed listener drops the enable and takes data
    curReq = "R5";
    mpEnable = 1'b0;
    playFrame(8'h99, 1'b0, 1'b1, -1, -1);
    expectVals("R5", 8'h99, 1'b0, 1'b1);
    hostClear();
    mpEnable = 1'b1;

    // R10: frame discarded while flag still set
    curReq = "R10";
    playFrame(8'h21, 1'b1, 1'b1, -1, -1);
    expectVals("R10", 8'h21, 1'b1, 1'b1);
    playFrame(8'h44, 1'b1, 1'b1, -1, -1);
    expectVals("R10", 8'h21, 1'b1, 1'b1);
    hostClear();
    expectVals("R10", 8'h21, 1'b1, 1'b0);

    // R6: ten-bit mode with stop checking
    curReq = "R6";
    nineBitMode = 1'b0;
    playFrame(8'hC3, 1'b0, 1'b1, -1, -1);
    expectVals("R6", 8'hC3, 1'b1, 1'b1);
    hostClear();
    playFrame(8'h0F, 1'b0, 1'b0, -1, -1);
    expectVals("R6", 8'hC3, 1'b1, 1'b0);

    // R7: ten-bit mode, enable off, bad stop still accepted
    curReq = "R7";
    mpEnable = 1'b0;
    playFrame(8'hF0, 1'b0, 1'b0, -1, -1);
    expectVals("R7", 8'hF0, 1'b0, 1'b1);
    hostClear();

    // R8: false start pulse then a good frame
    curReq = "R8";
    while ((cyc + 2) % 4 != 0) step(1'b1, 1'b0);
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0);
    for (int k = 0; k < 200; k++) step(1'b1, 1'b0);
    expectVals("R8", 8'hF0, 1'b0, 1'b0);
    playFrame(8'h81, 1'b0, 1'b1, -1, -1);
    expectVals("R8", 8'h81, 1'b1, 1'b1);
    hostClear();

    // R9: single-sample glitches on data bit 0 and the ninth bit
    curReq = "R9";
    nineBitMode = 1'b1;
    playFrame(8'h55, 1'b0, 1'b1, 1, 9);
    expectVals("R9", 8'h55, 1'b0, 1'b1);
    hostClear();
    playFrame(8'hAA, 1'b1, 1'b1, 4, 8);
    expectVals("R9", 8'hAA, 1'b1, 1'b1);
    hostClear();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule